// File: doc/BRIEF.md
# USB Suspend Resume Wakeup Detector

This block watches the raw USB data lines while the link is suspended. When the host signals resume by driving the K line state, it raises a wakeup request toward the clock controller. The request comes straight from the unfiltered pin levels through combinational qualification, so it works while the USB clocks are stopped. The qualification gates are: device mode, transceiver suspended, and a software enable. For full-speed signalling the K state is D+ low with D- high.

The same qualified condition passes through a synchroniser into the bus clock domain. There it sets a sticky resume status bit. A second sticky bit records a synchronous interrupt detection reported by the protocol engine. Software reads both bits through an 8-bit read port and clears them by writing 1. A clear loses to a source that is still active in the same cycle.

Top module: `usbwk_top`

## Requirements
- R1: `wake_req` is 1 exactly when `usb_dp`=0, `usb_dm`=1, `dev_mode`=1, `xcvr_susp`=1 and `wake_en`=1, with no clock edge needed.
- R2: With `wake_en`=0, `wake_req` stays 0 and the resume status bit is never set.
- R3: With `dev_mode`=0 (host mode), `wake_req` stays 0 and the resume status bit is never set.
- R4: With `xcvr_susp`=0, `wake_req` stays 0 and the resume status bit is never set.
- R5: The line states J (dp=1, dm=0), SE0 (00) and SE1 (11) never qualify.
- R6: Suppose a qualified K state is present before clock edge n. The resume status bit (`reg_rdata[0]`) is then 1 after edge n+2, and not yet 1 after edge n+1. Once set, it stays 1 after the K state goes away.
- R7: A write with `reg_wr`=1 and `reg_wdata[0]`=1 clears the resume bit on that edge, provided the synchronised condition is inactive. A write with `reg_wdata[0]`=0 leaves the bit unchanged.
- R8: A clear of the resume bit is ignored while the synchronised condition is still active, and the bit stays 1.
- R9: `sync_evt`=1 at an edge sets the sync-detect bit (`reg_rdata[1]`) on that edge. The bit is sticky. A write with `reg_wdata[1]`=1 clears it, unless `sync_evt` is 1 in the same cycle.
- R10: Bits 7:2 of `reg_rdata` always read 0.
- R11: Synchronous active-high `rst` clears both status bits and the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| usb_dp | input | 1 | Raw D+ pin level, unsynchronised |
| usb_dm | input | 1 | Raw D- pin level, unsynchronised |
| dev_mode | input | 1 | 1 = device mode, 0 = host mode |
| xcvr_susp | input | 1 | 1 = transceiver suspended |
| wake_en | input | 1 | Software enable for asynchronous wakeup |
| sync_evt | input | 1 | Synchronous interrupt detected pulse |
| reg_wr | input | 1 | Status write strobe |
| reg_wdata | input | 2 | Write-1-to-clear mask: bit0 resume, bit1 sync-detect |
| reg_rdata | output | 8 | Status read value |
| wake_req | output | 1 | Asynchronous wakeup request to clock controller |

## Verification
The bench walks every combination of gate inputs and line states. A detector that decoded J as K, or that ignored one gate, would raise `wake_req` or set the status bit when it should not. Directed sequences check the synchroniser latency cycle by cycle, so a design with a missing or extra stage sets the bit one edge off. Clears are issued while the K state persists and again after it is gone. A design that let the clear win would drop the bit and then set it again a few cycles later. A design that ignored the clear would keep the bit at 1. Simultaneous sync events and clears catch the wrong priority on the second bit.

// File: rtl/usbwk_pkg.sv
package usbwk_pkg;
    localparam int REG_W   = 8;
    localparam int STAT_W  = 2;
    localparam int RES_BIT = 0;
    localparam int SYN_BIT = 1;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_K   = 2'b01,
        LS_J   = 2'b10,
        LS_SE1 = 2'b11
    } line_state_e;

    typedef struct packed {
        logic sync_det;
        logic resume;
    } wk_status_t;

    function automatic line_state_e decode_line(input logic dp, input logic dm);
        return line_state_e'({dp, dm});
    endfunction
endpackage

// File: rtl/usbwk_kdetect.sv
module usbwk_kdetect
    import usbwk_pkg::*;
(
    input  logic usb_dp,
    input  logic usb_dm,
    input  logic dev_mode,
    input  logic xcvr_susp,
    input  logic wake_en,
    output logic k_qual
);
    line_state_e ls;
    logic        gate_ok;

    always_comb begin
        ls      = decode_line(usb_dp, usb_dm);
        gate_ok = dev_mode & xcvr_susp & wake_en;
        k_qual  = gate_ok & (ls == LS_K);
    end
endmodule

// File: rtl/usbwk_sync.sv
module usbwk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/usbwk_status.sv
module usbwk_status
    import usbwk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              res_set,
    input  logic              syn_set,
    input  logic              wr,
    input  logic [STAT_W-1:0] wmask,
    output logic [REG_W-1:0]  rdata
);
    wk_status_t st;
    logic       clr_res, clr_syn;

    always_comb begin
        clr_res = wr & wmask[RES_BIT];
        clr_syn = wr & wmask[SYN_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.resume   <= res_set | (st.resume   & ~clr_res);
            st.sync_det <= syn_set | (st.sync_det & ~clr_syn);
        end
    end

    always_comb begin
        rdata          = '0;
        rdata[RES_BIT] = st.resume;
        rdata[SYN_BIT] = st.sync_det;
    end

    assert_set_R6: assert property (@(posedge clk) disable iff (rst)
        res_set |=> st.resume);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (st.resume && !clr_res) |=> st.resume);
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_res && !res_set) |=> !st.resume);
    assert_sync_set_R9: assert property (@(posedge clk) disable iff (rst)
        syn_set |=> st.sync_det);
    assert_sync_clr_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_syn && !syn_set) |=> !st.sync_det);
endmodule

// File: rtl/usbwk_top.sv
module usbwk_top
    import usbwk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usb_dp,
    input  logic              usb_dm,
    input  logic              dev_mode,
    input  logic              xcvr_susp,
    input  logic              wake_en,
    input  logic              sync_evt,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              wake_req
);
    logic k_qual;
    logic k_sync;

    usbwk_kdetect u_det (
        .usb_dp    (usb_dp),
        .usb_dm    (usb_dm),
        .dev_mode  (dev_mode),
        .xcvr_susp (xcvr_susp),
        .wake_en   (wake_en),
        .k_qual    (k_qual)
    );

    usbwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (k_qual),
        .q_sync  (k_sync)
    );

    usbwk_status u_stat (
        .clk     (clk),
        .rst     (rst),
        .res_set (k_sync),
        .syn_set (sync_evt),
        .wr      (reg_wr),
        .wmask   (reg_wdata),
        .rdata   (reg_rdata)
    );

    assign wake_req = k_qual;

    assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> wake_en);
    assert_host_R3: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> dev_mode);
    assert_susp_R4: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> xcvr_susp);
    assert_kstate_R5: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (!usb_dp && usb_dm));
    assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[REG_W-1:STAT_W] == '0);
endmodule

// File: tb/tb_usbwk_top.sv
module tb_usbwk_top;
    logic clk = 1'b0;
    logic rst;
    logic usb_dp, usb_dm, dev_mode, xcvr_susp, wake_en, sync_evt, reg_wr;
    logic [1:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic wake_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic m_s1, m_s2, m_res, m_syn;

    always #2 clk = ~clk;

    usbwk_top dut (
        .clk(clk), .rst(rst), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .dev_mode(dev_mode), .xcvr_susp(xcvr_susp), .wake_en(wake_en),
        .sync_evt(sync_evt), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wake_req(wake_req)
    );

    function automatic logic exp_wake(logic dp, logic dm, logic dv, logic su, logic en);
        return en & dv & su & ~dp & dm;
    endfunction

    function automatic string wake_tag(logic dp, logic dm, logic dv, logic su, logic en);
        if (!en) return "R2";
        if (!dv) return "R3";
        if (!su) return "R4";
        if (!(~dp & dm)) return "R5";
        return "R1";
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle at negedge, check, then advance model over the posedge
    task automatic step(input logic dp, dm, dv, su, en, se, wr, input logic [1:0] wd);
        logic q;
        usb_dp = dp; usb_dm = dm; dev_mode = dv; xcvr_susp = su; wake_en = en;
        sync_evt = se; reg_wr = wr; reg_wdata = wd;
        #1;
        chk(wake_tag(dp, dm, dv, su, en), {7'd0, wake_req}, {7'd0, exp_wake(dp, dm, dv, su, en)});
        chk("R6", {7'd0, reg_rdata[0]}, {7'd0, m_res});
        chk("R9", {7'd0, reg_rdata[1]}, {7'd0, m_syn});
        chk("R10", {2'd0, reg_rdata[7:2]}, 8'd0);
        q = exp_wake(dp, dm, dv, su, en);
        @(posedge clk);
        m_res = m_s2 | (m_res & ~(wr & wd[0]));
        m_syn = se | (m_syn & ~(wr & wd[1]));
        m_s2 = m_s1;
        m_s1 = q;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 1, 1, 0, 0, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1;
        usb_dp = 0; usb_dm = 0; dev_mode = 0; xcvr_susp = 0; wake_en = 0;
        sync_evt = 1; reg_wr = 0; reg_wdata = 0;
        usb_dp = 0; usb_dm = 1; dev_mode = 1; xcvr_susp = 1; wake_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset holds status at zero despite active sources
        chk("R11", reg_rdata, 8'h00);
        rst = 1'b0;
        m_s1 = 0; m_s2 = 0; m_res = 0; m_syn = 0;
        usb_dp = 0; usb_dm = 0; sync_evt = 0;
        @(negedge clk);
        chk("R11", reg_rdata, 8'h00);

        // R6 latency: K before edge n, not set after n+1, set after n+2
        step(0, 1, 1, 1, 1, 0, 0, 2'b00);
        chk("R6", {7'd0, reg_rdata[0]}, 8'd0);
        step(0, 0, 1, 1, 1, 0, 0, 2'b00);
        chk("R6", {7'd0, reg_rdata[0]}, 8'd0);
        step(0, 0, 1, 1, 1, 0, 0, 2'b00);
        chk("R6", {7'd0, reg_rdata[0]}, 8'd1);
        idle(3);
        chk("R6", {7'd0, reg_rdata[0]}, 8'd1);
        // R7: writing 0 keeps, writing 1 clears
        step(0, 0, 1, 1, 1, 0, 1, 2'b10);
        chk("R7", {7'd0, reg_rdata[0]}, 8'd1);
        step(0, 0, 1, 1, 1, 0, 1, 2'b01);
        chk("R7", {7'd0, reg_rdata[0]}, 8'd0);

        // R8: clear while K persists is ignored
        for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 1, 0, 0, 2'b00);
        step(0, 1, 1, 1, 1, 0, 1, 2'b01);
        chk("R8", {7'd0, reg_rdata[0]}, 8'd1);
        idle(3);
        step(0, 0, 1, 1, 1, 0, 1, 2'b01);
        chk("R7", {7'd0, reg_rdata[0]}, 8'd0);

        // R2/R3/R4/R5: held K with one gate off, or non-K line states
        for (int g = 0; g < 7; g++) begin
            for (int i = 0; i < 4; i++) begin
                case (g)
                    0: step(0, 1, 1, 1, 0, 0, 0, 2'b00);
                    1: step(0, 1, 0, 1, 1, 0, 0, 2'b00);
                    2: step(0, 1, 1, 0, 1, 0, 0, 2'b00);
                    3: step(1, 0, 1, 1, 1, 0, 0, 2'b00);
                    4: step(0, 0, 1, 1, 1, 0, 0, 2'b00);
                    default: step(1, 1, 1, 1, 1, 0, 0, 2'b00);
                endcase
            end
            chk(g == 0 ? "R2" : g == 1 ? "R3" : g == 2 ? "R4" : "R5",
                {7'd0, reg_rdata[0]}, 8'd0);
        end

        // R9: set, sticky, clear, simultaneous event wins
        step(0, 0, 1, 1, 1, 1, 0, 2'b00);
        chk("R9", {7'd0, reg_rdata[1]}, 8'd1);
        step(0, 0, 1, 1, 1, 0, 1, 2'b01);
        chk("R9", {7'd0, reg_rdata[1]}, 8'd1);
        step(0, 0, 1, 1, 1, 1, 1, 2'b10);
        chk("R9", {7'd0, reg_rdata[1]}, 8'd1);
        step(0, 0, 1, 1, 1, 0, 1, 2'b10);
        chk("R9", {7'd0, reg_rdata[1]}, 8'd0);

        // constrained random, checked against the model inside step
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] ln;
            ln = 2'($urandom);
            if (($urandom % 2) == 0) ln = 2'b01;
            step(ln[1], ln[0], ($urandom % 6) != 0, ($urandom % 6) != 0,
                 ($urandom % 6) != 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                 2'($urandom));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule